// File: doc/BRIEF.md
# Serial NOR Flash Erase Sequencer

This block launches erase operations on an external serial NOR flash over a single-line SPI link in mode 0. Software sets up a small set of write-only registers: the erase start address, a two-bit size code, an address-width bit and an interrupt enable. It then writes the start register. The sequencer reads the flash status register until the write-in-progress bit is clear, sends a write-enable command in its own chip-select frame, and then sends the erase opcode for the chosen size. The erase frame carries the address bytes when the size needs them.

When the erase frame closes, a ready event is raised and, if enabled, an interrupt. The event does not wait for the flash to finish erasing. The flash's own busy period is absorbed by the status poll at the start of the next operation. Software clears the event by writing zero to it.

Top module: `erase_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and ready_evt, irq and busy are all 0.
- R2: Each accepted start begins with one or more status frames. Each status frame is opcode 0x05 followed by one byte read on spi_miso. The frame repeats while bit 0 of the returned byte is 1, and the sequence moves on after the first frame that returns bit 0 clear.
- R3: A one-byte frame holding opcode 0x06 comes between the last status frame and the erase frame.
- R4: Size code 0 sends opcode 0x20 and size code 1 sends opcode 0xD8, each followed by the address most significant byte first. Size code 2 sends opcode 0xC7 with no address bytes.
- R5: With the address-width bit at 0, the erase frame carries bits 23:0 of the pointer (3 bytes). With it at 1, the frame carries all 32 bits (4 bytes).
- R6: ready_evt goes to 1 in the same cycle that busy falls, right after the erase frame closes, with no wait for the flash to finish.
- R7: Writing 0 to the event register clears ready_evt. Writing any nonzero value to it leaves ready_evt unchanged.
- R8: irq is 1 exactly when ready_evt is 1 and bit 0 of the interrupt-enable register is 1.
- R9: A start write that arrives while busy is ignored. Pointer or size writes made while busy do not change the operation already running.
- R10: Size code 3 is reserved. A start write made with size code 3 launches nothing.
- R11: The SPI link runs in mode 0. spi_sck idles low and is high only while spi_cs_n is low. spi_mosi carries each byte most significant bit first and is stable across each rising SCK edge. spi_miso is sampled while SCK is high.
- R12: Register selects are 0 start (a write with bit 0 set launches; a write with bit 0 clear does nothing), 1 event, 2 interrupt enable (bit 0), 3 pointer (32 bits), 4 size code (bits 1:0) and 5 address width (bit 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| ready_evt | output | 1 | Erase-launched event flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Operation in progress |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench models the flash at the pins and decodes every chip-select frame. It makes the status poll return a busy flag for a chosen number of rounds, with other status bits set as well. A design that tested the wrong status bit, or skipped the poll, would show the wrong number of 0x05 frames. Chip erase is checked for a frame with no address bytes. A high pointer byte is used in 24-bit mode, so that a design sending four bytes, or the wrong three, produces a frame of the wrong length or content. The bench also sends a start, a new pointer and a new size in the middle of an operation, and sends a start with the reserved size code. A design that restarted, relatched, or launched on either of these would leave extra frames or a changed address in the log.

// File: rtl/erase_pkg.sv
package erase_pkg;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_EVENT = 3'd1;
  localparam logic [2:0] SEL_INTEN = 3'd2;
  localparam logic [2:0] SEL_PTR   = 3'd3;
  localparam logic [2:0] SEL_SIZE  = 3'd4;
  localparam logic [2:0] SEL_AMODE = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL_CMD, ST_POLL_DATA, ST_WREN, ST_ERASE_CMD,
    ST_ADDR, ST_GAP, ST_FINISH
  } seq_state_e;

  function automatic logic [7:0] erase_opcode(input logic [1:0] code);
    case (code)
      2'd0:    erase_opcode = 8'h20;
      2'd1:    erase_opcode = 8'hD8;
      default: erase_opcode = 8'hC7;
    endcase
  endfunction

  function automatic logic [2:0] addr_byte_count(input logic [1:0] code,
                                                 input logic       wide);
    if (code == 2'd2) addr_byte_count = 3'd0;
    else if (wide)    addr_byte_count = 3'd4;
    else              addr_byte_count = 3'd3;
  endfunction

  function automatic logic size_is_valid(input logic [1:0] code);
    size_is_valid = (code != 2'd3);
  endfunction

endpackage

// File: rtl/erase_regs.sv
module erase_regs
  import erase_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              evt_set,
  output logic              start_req,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [1:0]        size_q,
  output logic              amode_q,
  output logic              evt_q,
  output logic              irq
);

  logic inten_q;

  assign start_req = reg_wr && (reg_sel == SEL_START) && reg_wdata[0];
  assign irq       = evt_q && inten_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      size_q  <= '0;
      amode_q <= 1'b0;
      inten_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_sel)
        SEL_PTR:   ptr_q   <= reg_wdata[ADDR_W-1:0];
        SEL_SIZE:  size_q  <= reg_wdata[1:0];
        SEL_AMODE: amode_q <= reg_wdata[0];
        SEL_INTEN: inten_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      evt_q <= 1'b0;
    else if (evt_set)
      evt_q <= 1'b1;
    else if (reg_wr && reg_sel == SEL_EVENT && reg_wdata == 32'd0)
      evt_q <= 1'b0;
  end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] tx,
  output logic              done,
  output logic              rx_last,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  localparam int CW = $clog2(BYTE_W);

  logic              active, phase;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic              last_bit;

  assign last_bit = (cnt == CW'(BYTE_W - 1));
  assign sck      = active && phase;
  assign mosi     = active ? sh[BYTE_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      rx_last <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          phase  <= 1'b0;
          cnt    <= '0;
          sh     <= tx;
        end
      end else if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase   <= 1'b0;
        sh      <= {sh[BYTE_W-2:0], 1'b0};
        rx_last <= miso;
        cnt     <= cnt + CW'(1);
        if (last_bit) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CS_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [1:0]        size_q,
  input  logic [ADDR_W-1:0] ptr_q,
  input  logic              amode_q,
  input  logic              sh_done,
  input  logic              wip_bit,
  output logic              sh_go,
  output logic [7:0]        sh_tx,
  output logic              cs_n,
  output logic              busy,
  output logic              evt_set
);

  localparam int GW = $clog2(CS_GAP + 1);

  seq_state_e        state, ret_state;
  logic [GW-1:0]     gap_cnt;
  logic [1:0]        op_size;
  logic [ADDR_W-1:0] op_addr;
  logic [2:0]        idx;
  logic              kicked;
  logic              in_frame;

  assign in_frame = (state == ST_POLL_CMD) || (state == ST_POLL_DATA) ||
                    (state == ST_WREN) || (state == ST_ERASE_CMD) ||
                    (state == ST_ADDR);
  assign cs_n    = !in_frame;
  assign busy    = (state != ST_IDLE);
  assign evt_set = (state == ST_FINISH);
  assign sh_go   = in_frame && !kicked;

  always_comb begin
    case (state)
      ST_POLL_CMD:  sh_tx = OP_RDSR;
      ST_WREN:      sh_tx = OP_WREN;
      ST_ERASE_CMD: sh_tx = erase_opcode(op_size);
      ST_ADDR:      sh_tx = op_addr[{idx[1:0], 3'b000} +: 8];
      default:      sh_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      gap_cnt   <= '0;
      op_size   <= '0;
      op_addr   <= '0;
      idx       <= '0;
      kicked    <= 1'b0;
    end else begin
      if (sh_go) kicked <= 1'b1;
      if (sh_done) kicked <= 1'b0;
      case (state)
        ST_IDLE:
          if (start_req && size_is_valid(size_q)) begin
            op_size <= size_q;
            op_addr <= ptr_q;
            idx     <= addr_byte_count(size_q, amode_q) - 3'd1;
            state   <= ST_POLL_CMD;
          end
        ST_POLL_CMD:
          if (sh_done) state <= ST_POLL_DATA;
        ST_POLL_DATA:
          if (sh_done) begin
            gap_cnt   <= '0;
            ret_state <= wip_bit ? ST_POLL_CMD : ST_WREN;
            state     <= ST_GAP;
          end
        ST_WREN:
          if (sh_done) begin
            gap_cnt   <= '0;
            ret_state <= ST_ERASE_CMD;
            state     <= ST_GAP;
          end
        ST_ERASE_CMD:
          if (sh_done)
            state <= (op_size == 2'd2) ? ST_FINISH : ST_ADDR;
        ST_ADDR:
          if (sh_done) begin
            if (idx == 3'd0) state <= ST_FINISH;
            else             idx   <= idx - 3'd1;
          end
        ST_GAP:
          if (gap_cnt == GW'(CS_GAP - 1)) state <= ret_state;
          else                            gap_cnt <= gap_cnt + GW'(1);
        ST_FINISH:
          state <= ST_IDLE;
        default:
          state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CS_GAP = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        ready_evt,
  output logic        irq,
  output logic        busy,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  logic              start_req, amode_q, evt_set;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              sh_go, sh_done, wip_bit;
  logic [7:0]        sh_tx;

  erase_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .evt_set(evt_set), .start_req(start_req),
    .ptr_q(ptr_q), .size_q(size_q), .amode_q(amode_q), .evt_q(ready_evt),
    .irq(irq)
  );

  erase_seq_ctrl #(.ADDR_W(ADDR_W), .CS_GAP(CS_GAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .size_q(size_q),
    .ptr_q(ptr_q), .amode_q(amode_q), .sh_done(sh_done), .wip_bit(wip_bit),
    .sh_go(sh_go), .sh_tx(sh_tx), .cs_n(spi_cs_n), .busy(busy),
    .evt_set(evt_set)
  );

  spi_byte_shifter #(.BYTE_W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx), .done(sh_done),
    .rx_last(wip_bit), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cs_n,
  input logic       sck,
  input logic       ready_evt,
  input logic       irq,
  input logic       start_req,
  input logic [1:0] size_q
);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));

  // R11
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  // R6
  evt_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_evt) |-> $fell(busy));

  // R8
  irq_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready_evt);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy && size_q != 2'd3) |=> busy);

  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy && size_q == 2'd3) |=> !busy);

endmodule

bind erase_seq erase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(spi_cs_n), .sck(spi_sck),
  .ready_evt(ready_evt), .irq(irq), .start_req(start_req), .size_q(size_q)
);

// File: tb/erase_seq_tb.sv
module erase_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        ready_evt, irq, busy, spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  erase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ready_evt(ready_evt), .irq(irq), .busy(busy),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // Pin-level flash model: logs each chip-select frame.
  int         bitc = 0;
  int         nfrm = 0;
  int         wip_left = 0;
  logic [7:0] cur = 8'd0;
  logic [7:0] stat = 8'd0;
  logic [7:0] fb [0:31][0:7];
  int         flen [0:31];

  always @(negedge spi_cs_n) bitc = 0;

  always @(posedge spi_sck) if (!spi_cs_n) begin
    cur  = {cur[6:0], spi_mosi};
    bitc = bitc + 1;
    if (bitc % 8 == 0 && bitc <= 64 && nfrm < 32) fb[nfrm][bitc/8-1] = cur;
    if (bitc == 8 && cur == 8'h05) begin
      if (wip_left > 0) begin
        stat = 8'h03;
        wip_left = wip_left - 1;
      end else begin
        stat = 8'h82;
      end
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n && bitc >= 8 && bitc < 16)
    spi_miso = stat[15-bitc];

  always @(posedge spi_cs_n) if (rst_n && nfrm < 32) begin
    flen[nfrm] = bitc / 8;
    nfrm = nfrm + 1;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "cs_n", spi_cs_n, 1);
    check("R1", "sck", spi_sck, 0);
    check("R1", "ready_evt", ready_evt, 0);
    check("R1", "irq", irq, 0);
    check("R1", "busy", busy, 0);
  endtask

  task automatic t_erase(input logic [1:0] code, input logic [31:0] addr,
                         input logic wide, input int polls,
                         input logic en);
    logic [7:0] op;
    int nb;
    int base;
    op = (code == 0) ? 8'h20 : (code == 1) ? 8'hD8 : 8'hC7;
    nb = (code == 2) ? 0 : (wide ? 4 : 3);
    wr(3'd4, {30'd0, code});
    wr(3'd3, addr);
    wr(3'd5, {31'd0, wide});
    wr(3'd2, {31'd0, en});
    wr(3'd1, 32'd0);
    wip_left = polls;
    nfrm = 0;
    wr(3'd0, 32'd1);
    check("R9", "busy after start", busy, 1);
    wait_idle();
    // R6: event already set on the first idle cycle
    check("R6", "ready_evt at busy fall", ready_evt, 1);
    check("R8", "irq", irq, en);
    check("R11", "lines idle", {spi_cs_n, spi_sck}, 2'b10);
    check("R2", "frame count", nfrm, polls + 3);
    for (int i = 0; i <= polls; i++) begin
      check("R2", "poll frame length", flen[i], 2);
      check("R2", "poll opcode", fb[i][0], 8'h05);
    end
    base = polls + 1;
    check("R3", "wren length", flen[base], 1);
    check("R3", "wren opcode", fb[base][0], 8'h06);
    check("R5", "erase frame length", flen[base+1], 1 + nb);
    check("R4", "erase opcode", fb[base+1][0], op);
    for (int j = 0; j < nb; j++)
      check("R5", "address byte (R11 msb first)", fb[base+1][j+1],
            8'(addr >> (8 * (nb - 1 - j))));
  endtask

  task automatic t_event_clear();
    check("R7", "event set before clear", ready_evt, 1);
    wr(3'd2, 32'd1);
    wr(3'd1, 32'h0000_0001);
    check("R7", "nonzero write keeps event", ready_evt, 1);
    check("R8", "irq with enable", irq, 1);
    wr(3'd2, 32'd0);
    check("R8", "irq masked", irq, 0);
    wr(3'd1, 32'd0);
    check("R7", "zero write clears event", ready_evt, 0);
  endtask

  task automatic t_busy_start();
    wr(3'd4, 32'd0);
    wr(3'd3, 32'h0000_ABCD);
    wr(3'd5, 32'd0);
    wr(3'd1, 32'd0);
    wip_left = 1;
    nfrm = 0;
    wr(3'd0, 32'd1);
    repeat (20) @(negedge clk);
    wr(3'd3, 32'h0011_2233);
    wr(3'd4, 32'd2);
    wr(3'd0, 32'd1);
    wait_idle();
    check("R9", "one operation only", nfrm, 4);
    check("R9", "opcode kept", fb[3][0], 8'h20);
    check("R9", "address kept", {fb[3][1], fb[3][2], fb[3][3]}, 24'h00ABCD);
    repeat (150) @(negedge clk);
    check("R9", "no restart", {busy, 8'(nfrm)}, {1'b0, 8'd4});
  endtask

  task automatic t_reserved();
    wr(3'd1, 32'd0);
    wr(3'd4, 32'd3);
    nfrm = 0;
    wr(3'd0, 32'd1);
    repeat (60) @(negedge clk);
    check("R10", "reserved size launches nothing",
          {busy, ready_evt, 8'(nfrm)}, 10'd0);
    wr(3'd4, 32'd1);
    wr(3'd0, 32'd0);
    repeat (60) @(negedge clk);
    check("R12", "start bit0 clear does nothing",
          {busy, ready_evt, 8'(nfrm)}, 10'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_erase(2'd0, 32'h0012_3456, 1'b0, 0, 1'b1);
    t_event_clear();
    t_erase(2'd1, 32'hA1B2_C3D4, 1'b1, 2, 1'b0);
    t_erase(2'd2, 32'h00FF_FFFF, 1'b1, 1, 1'b1);
    t_erase(2'd1, 32'hFF65_4321, 1'b0, 0, 1'b1);
    t_busy_start();
    t_reserved();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule